// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block is a small bus-based shared-memory system. It holds two per-processor cache controllers, one shared bus with a fixed two-way grant, and a port to an external memory. Each controller keeps a few direct-mapped cache blocks, each with a tag, one data word and a coherence state. Every controller watches each transaction on the bus. When another cache reads a block it has modified, it supplies the data and flushes it to memory. When another cache writes or invalidates a block it holds, it drops its own copy.

A static two-bit policy input selects one of three write-invalidate schemes. In write-through mode every write reaches memory. In ownership mode a writer becomes the sole owner and memory is updated only when the block is replaced. In write-once mode the first write to a shared block goes to memory and later writes stay in the cache until replacement. A processor issues one request at a time (read, write or evict). It receives a one-cycle done pulse together with the block's coherence state before and after the access.

Top module: `coh_snoop_sys`

## Requirements
- R1: After reset every block in both caches is Invalid (code 0), the bus command output is idle (code 0) and no done pulse is asserted.
- R2: A read that misses issues one bus read (command code 1), loads the block as Shared (code 1) and returns the memory word. A read that hits returns the cached word with no bus traffic.
- R3: When a bus read targets a block that another cache holds Dirty (code 3), that cache supplies the data in the same bus cycle. The word is written to memory in that cycle, the requester receives the supplied word, and the supplier's copy becomes Shared.
- R4: With policy 0 (write-through), every processor write issues a bus write (code 2) that updates memory. The writer's block stays Shared.
- R5: With policy 1 (ownership), a write to a Shared block issues a bus invalidate (code 3), leaves memory unchanged and makes the block Dirty. A write to a Dirty block causes no bus traffic.
- R6: With policy 2 (write-once), a write to a Shared block issues a bus write that updates memory and makes the block Reserved (code 2). A write to a Reserved or Dirty block causes no bus traffic and leaves it Dirty.
- R7: A cache holding a block that another cache writes or invalidates on the bus shows that block Invalid from the next cycle. A cache holding a block Reserved that another cache reads moves it to Shared.
- R8: A miss whose direct-mapped frame (address bits [1:0] with the default size) holds another block in Dirty state first issues a bus write-back (code 4) of that block, then the bus read. A clean or Reserved victim is dropped with no bus traffic.
- R9: An evict request (op code 2) on a Dirty block issues one bus write-back and leaves the block Invalid. On a clean or Reserved block, or on a miss, it causes no bus traffic.
- R10: Each request (op codes: 0 read, 1 write, 2 evict) ends with a single-cycle done pulse. The reported pre-state is the block's state when the request first wins the bus, or Invalid on a miss, and the post-state is its state after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy: 0 write-through, 1 ownership, 2 write-once |
| cpu_req | input | NCPU | Request strobe, one bit per processor |
| cpu_op | input | 2*NCPU | Operation per processor: 0 read, 1 write, 2 evict |
| cpu_addr | input | AW*NCPU | Block address per processor |
| cpu_wdata | input | DW*NCPU | Write data per processor |
| cpu_done | output | NCPU | One-cycle completion pulse per processor |
| cpu_rdata | output | DW*NCPU | Block data after the request |
| cpu_pre_state | output | 2*NCPU | Block state before the request |
| cpu_post_state | output | 2*NCPU | Block state after the request |
| bus_cmd_o | output | 3 | Command on the shared bus: 0 idle, 1 read, 2 write, 3 invalidate, 4 write-back |
| bus_addr_o | output | AW | Address on the shared bus |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle as mem_addr |

## Verification
The hardest situation to reach is a miss whose frame holds a Dirty block while the other cache holds the requested block Dirty. That request needs a write-back followed by a read served by a snoop flush. The stimulus builds it by writing one address in the first cache and a different address that maps to the same frame in the second cache, then having the first cache read the second address. The same seven-step sequence on one location then runs under all three policies, so the Reserved state and the invalidations appear only where the selected policy produces them.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_RSV = 2'd2,
        ST_DRT = 2'd3
    } blk_st_t;

    typedef enum logic [2:0] {
        BC_NONE = 3'd0,
        BC_RD   = 3'd1,
        BC_WR   = 3'd2,
        BC_INV  = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_t;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2
    } cpu_op_t;

    typedef enum logic [1:0] {
        MD_WTHRU = 2'd0,
        MD_OWNER = 2'd1,
        MD_ONCE  = 2'd2
    } policy_t;

endpackage

// File: rtl/coh_bus_arb.sv
module coh_bus_arb
    import coh_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int AW   = 4,
    parameter int DW   = 8
) (
    input  logic [NCPU-1:0]      req,
    input  logic [NCPU*3-1:0]    req_cmd,
    input  logic [NCPU*AW-1:0]   req_addr,
    input  logic [NCPU*DW-1:0]   req_wdata,
    input  logic [NCPU-1:0]      snp_dirty,
    input  logic [NCPU*DW-1:0]   snp_data,
    input  logic [DW-1:0]        mem_rdata,
    output logic [NCPU-1:0]      gnt,
    output logic [2:0]           bus_cmd,
    output logic [AW-1:0]        bus_addr,
    output logic [DW-1:0]        rd_data,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata
);

    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] sup_data;
    logic          supply;
    bus_cmd_t      cmd_e;

    // fixed priority: lowest index wins
    always_comb begin
        gnt       = '0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        for (int i = NCPU - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt       = '0;
                gnt[i]    = 1'b1;
                bus_cmd   = req_cmd[i*3 +: 3];
                bus_addr  = req_addr[i*AW +: AW];
                bus_wdata = req_wdata[i*DW +: DW];
            end
        end
    end

    // data path: snoop supply overrides memory and flushes it
    always_comb begin
        cmd_e    = bus_cmd_t'(bus_cmd);
        supply   = |snp_dirty;
        sup_data = '0;
        for (int i = 0; i < NCPU; i++) begin
            if (snp_dirty[i]) sup_data = sup_data | snp_data[i*DW +: DW];
        end
        rd_data   = supply ? sup_data : mem_rdata;
        mem_addr  = bus_addr;
        mem_we    = (cmd_e == BC_WR) || (cmd_e == BC_WB) ||
                    ((cmd_e == BC_RD) && supply);
        mem_wdata = (cmd_e == BC_RD) ? sup_data : bus_wdata;
    end

endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
    import coh_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          cpu_req,
    input  logic [1:0]    cpu_op,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic [1:0]    cpu_pre,
    output logic [1:0]    cpu_post,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [2:0]    req_cmd,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic [2:0]    bus_cmd,
    input  logic [AW-1:0] bus_addr,
    output logic          snp_dirty,
    output logic [DW-1:0] snp_data
);

    localparam int IW = $clog2(NL);
    localparam int TW = AW - IW;

    typedef enum logic [1:0] {F_IDLE, F_LOOK, F_RESP} fsm_t;

    typedef struct packed {
        fsm_t                   fsm;
        logic [1:0]             op;
        logic [AW-1:0]          addr;
        logic [DW-1:0]          wdata;
        logic                   first;
        logic [1:0]             pre;
        logic [1:0]             post;
        logic [DW-1:0]          rdata;
        logic [NL-1:0][1:0]     st;
        logic [NL-1:0][TW-1:0]  tag;
        logic [NL-1:0][DW-1:0]  dat;
    } ctrl_t;

    ctrl_t d, q;

    // decision for the pending request, from registered state only
    logic [IW-1:0] idx;
    logic [TW-1:0] tg;
    blk_st_t       cur, nxt_st;
    logic          hit, fill, wr, fin;
    bus_cmd_t      dcmd;
    logic [AW-1:0] daddr;
    logic [DW-1:0] ddata;
    cpu_op_t       op_e;
    policy_t       md;

    always_comb begin
        idx    = q.addr[IW-1:0];
        tg     = q.addr[AW-1:IW];
        cur    = blk_st_t'(q.st[idx]);
        hit    = (cur != ST_INV) && (q.tag[idx] == tg);
        op_e   = cpu_op_t'(q.op);
        md     = policy_t'(mode);
        dcmd   = BC_NONE;
        daddr  = q.addr;
        ddata  = q.wdata;
        nxt_st = cur;
        fill   = 1'b0;
        wr     = 1'b0;
        fin    = 1'b0;
        if (op_e == OP_EVICT) begin
            fin = 1'b1;
            if (hit) begin
                nxt_st = ST_INV;
                if (cur == ST_DRT) begin
                    dcmd  = BC_WB;
                    ddata = q.dat[idx];
                end
            end
        end else if (!hit && cur == ST_DRT) begin
            dcmd   = BC_WB;
            daddr  = {q.tag[idx], idx};
            ddata  = q.dat[idx];
            nxt_st = ST_INV;
        end else if (!hit) begin
            dcmd   = BC_RD;
            fill   = 1'b1;
            nxt_st = ST_SHR;
            fin    = (op_e == OP_RD);
        end else if (op_e == OP_RD) begin
            fin = 1'b1;
        end else begin
            wr  = 1'b1;
            fin = 1'b1;
            case (md)
                MD_WTHRU: begin
                    dcmd   = BC_WR;
                    nxt_st = ST_SHR;
                end
                MD_OWNER: begin
                    if (cur == ST_SHR) dcmd = BC_INV;
                    nxt_st = ST_DRT;
                end
                MD_ONCE: begin
                    if (cur == ST_SHR) begin
                        dcmd   = BC_WR;
                        nxt_st = ST_RSV;
                    end else begin
                        nxt_st = ST_DRT;
                    end
                end
                default: nxt_st = cur;
            endcase
        end
    end

    always_comb begin
        bus_req   = (q.fsm == F_LOOK);
        req_cmd   = (q.fsm == F_LOOK) ? dcmd : BC_NONE;
        req_addr  = daddr;
        req_wdata = ddata;
    end

    // snoop lookup
    logic [IW-1:0] sidx;
    logic [TW-1:0] stg;
    logic          smatch;
    bus_cmd_t      scmd;

    always_comb begin
        sidx      = bus_addr[IW-1:0];
        stg       = bus_addr[AW-1:IW];
        scmd      = bus_cmd_t'(bus_cmd);
        smatch    = !bus_gnt && (blk_st_t'(q.st[sidx]) != ST_INV) &&
                    (q.tag[sidx] == stg);
        snp_dirty = smatch && (scmd == BC_RD) &&
                    (blk_st_t'(q.st[sidx]) == ST_DRT);
        snp_data  = q.dat[sidx];
    end

    // next-state
    always_comb begin
        d = q;
        case (q.fsm)
            F_IDLE: begin
                if (cpu_req) begin
                    d.fsm   = F_LOOK;
                    d.op    = cpu_op;
                    d.addr  = cpu_addr;
                    d.wdata = cpu_wdata;
                    d.first = 1'b1;
                end
            end
            F_LOOK: begin
                if (bus_gnt) begin
                    d.st[idx] = nxt_st;
                    if (fill) begin
                        d.tag[idx] = tg;
                        d.dat[idx] = bus_rdata;
                    end
                    if (wr) d.dat[idx] = q.wdata;
                    if (q.first) begin
                        d.pre   = hit ? cur : ST_INV;
                        d.first = 1'b0;
                    end
                    if (fin) begin
                        d.fsm   = F_RESP;
                        d.post  = nxt_st;
                        d.rdata = wr ? q.wdata : (fill ? bus_rdata : q.dat[idx]);
                    end
                end
            end
            F_RESP:  d.fsm = F_IDLE;
            default: d.fsm = F_IDLE;
        endcase
        if (smatch) begin
            case (scmd)
                BC_RD:         d.st[sidx] = ST_SHR;
                BC_WR, BC_INV: d.st[sidx] = ST_INV;
                default:       d.st[sidx] = q.st[sidx];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_done  = (q.fsm == F_RESP);
    assign cpu_rdata = q.rdata;
    assign cpu_pre   = q.pre;
    assign cpu_post  = q.post;

endmodule

// File: rtl/coh_snoop_sys.sv
module coh_snoop_sys
    import coh_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int AW   = 4,
    parameter int DW   = 8,
    parameter int NL   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [NCPU-1:0]      cpu_req,
    input  logic [NCPU*2-1:0]    cpu_op,
    input  logic [NCPU*AW-1:0]   cpu_addr,
    input  logic [NCPU*DW-1:0]   cpu_wdata,
    output logic [NCPU-1:0]      cpu_done,
    output logic [NCPU*DW-1:0]   cpu_rdata,
    output logic [NCPU*2-1:0]    cpu_pre_state,
    output logic [NCPU*2-1:0]    cpu_post_state,
    output logic [2:0]           bus_cmd_o,
    output logic [AW-1:0]        bus_addr_o,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata
);

    logic [NCPU-1:0]    req, gnt, snp_dirty;
    logic [NCPU*3-1:0]  req_cmd;
    logic [NCPU*AW-1:0] req_addr;
    logic [NCPU*DW-1:0] req_wdata, snp_data;
    logic [DW-1:0]      rd_data;

    for (genvar g = 0; g < NCPU; g++) begin : g_cache
        coh_cache_ctrl #(.AW(AW), .DW(DW), .NL(NL)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .cpu_req   (cpu_req[g]),
            .cpu_op    (cpu_op[g*2 +: 2]),
            .cpu_addr  (cpu_addr[g*AW +: AW]),
            .cpu_wdata (cpu_wdata[g*DW +: DW]),
            .cpu_done  (cpu_done[g]),
            .cpu_rdata (cpu_rdata[g*DW +: DW]),
            .cpu_pre   (cpu_pre_state[g*2 +: 2]),
            .cpu_post  (cpu_post_state[g*2 +: 2]),
            .bus_req   (req[g]),
            .bus_gnt   (gnt[g]),
            .req_cmd   (req_cmd[g*3 +: 3]),
            .req_addr  (req_addr[g*AW +: AW]),
            .req_wdata (req_wdata[g*DW +: DW]),
            .bus_rdata (rd_data),
            .bus_cmd   (bus_cmd_o),
            .bus_addr  (bus_addr_o),
            .snp_dirty (snp_dirty[g]),
            .snp_data  (snp_data[g*DW +: DW])
        );
    end

    coh_bus_arb #(.NCPU(NCPU), .AW(AW), .DW(DW)) u_arb (
        .req       (req),
        .req_cmd   (req_cmd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .snp_dirty (snp_dirty),
        .snp_data  (snp_data),
        .mem_rdata (mem_rdata),
        .gnt       (gnt),
        .bus_cmd   (bus_cmd_o),
        .bus_addr  (bus_addr_o),
        .rd_data   (rd_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/coh_snoop_sys_chk.sv
module coh_snoop_sys_chk #(
    parameter int NCPU = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [NCPU-1:0]   cpu_done,
    input logic [NCPU*2-1:0] cpu_post_state,
    input logic [2:0]        bus_cmd_o,
    input logic              mem_we
);

    // R4: write-through never invalidates or writes back
    a_r4_wthru_cmds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (bus_cmd_o != 3'd3 && bus_cmd_o != 3'd4));

    // R5: ownership never writes through
    a_r5_owner_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (bus_cmd_o != 3'd2));

    // R5: an invalidate leaves memory untouched
    a_r5_inv_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == 3'd3) |-> !mem_we);

    // R3: memory is only written during a bus data transfer
    a_r3_mem_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2 || bus_cmd_o == 3'd4));

    // R1: nothing happens on the first cycle out of reset
    a_r1_quiet_start: assert property (@(posedge clk)
        !rst_n |=> (cpu_done == '0));

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        // R10: done lasts one cycle
        a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_done[g] |=> !cpu_done[g]);
        // R6: Reserved appears only under write-once
        a_r6_rsv_once: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_done[g] && cpu_post_state[g*2 +: 2] == 2'd2) |-> (mode == 2'd2));
        // R4: Dirty never appears under write-through
        a_r4_no_dirty: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_done[g] && cpu_post_state[g*2 +: 2] == 2'd3) |-> (mode != 2'd0));
    end

endmodule

bind coh_snoop_sys coh_snoop_sys_chk #(.NCPU(NCPU)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode),
    .cpu_done       (cpu_done),
    .cpu_post_state (cpu_post_state),
    .bus_cmd_o      (bus_cmd_o),
    .mem_we         (mem_we)
);

// File: tb/coh_snoop_sys_test.sv
module coh_snoop_sys_test;

    localparam int NCPU = 2;
    localparam int AW   = 4;
    localparam int DW   = 8;
    localparam int NA   = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           mode = 2'd0;
    logic [NCPU-1:0]      cpu_req = '0;
    logic [NCPU*2-1:0]    cpu_op = '0;
    logic [NCPU*AW-1:0]   cpu_addr = '0;
    logic [NCPU*DW-1:0]   cpu_wdata = '0;
    logic [NCPU-1:0]      cpu_done;
    logic [NCPU*DW-1:0]   cpu_rdata;
    logic [NCPU*2-1:0]    cpu_pre_state, cpu_post_state;
    logic [2:0]           bus_cmd_o;
    logic [AW-1:0]        bus_addr_o;
    logic                 mem_we;
    logic [AW-1:0]        mem_addr;
    logic [DW-1:0]        mem_wdata, mem_rdata;

    logic [DW-1:0] mem_arr [NA];

    int n_tests = 0;
    int n_fail  = 0;
    int bus_cnt [5];

    // reference model
    int mst  [2][NA];
    int mdat [2][NA];
    int mmem [NA];

    always #5 clk = ~clk;

    coh_snoop_sys #(.NCPU(NCPU), .AW(AW), .DW(DW), .NL(4)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .cpu_pre_state(cpu_pre_state), .cpu_post_state(cpu_post_state),
        .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem_arr[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem_arr[mem_addr] <= mem_wdata;
    end

    always @(negedge clk) begin
        if (rst_n && bus_cmd_o != 3'd0 && bus_cmd_o < 3'd5) bus_cnt[bus_cmd_o] = bus_cnt[bus_cmd_o] + 1;
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic start(input int md);
        rst_n = 1'b0;
        mode  = md[1:0];
        @(negedge clk);
        for (int a = 0; a < NA; a++) begin
            mem_arr[a] = DW'(a * 3 + 1);
            mmem[a]    = a * 3 + 1;
            for (int c = 0; c < 2; c++) begin
                mst[c][a]  = 0;
                mdat[c][a] = 0;
            end
        end
        mem_arr[5] = 8'd5;
        mmem[5]    = 5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", int'(cpu_done), 0);
        check("R1", "bus idle after reset", int'(bus_cmd_o), 0);
    endtask

    // one request, compared with the behavioural model
    task automatic do_op(input int c, input int op, input int a, input int wd);
        int o, pre, post, rd, cur, guard;
        int ec [5];
        int bad, bad_a;
        string ptag;
        o = 1 - c;
        for (int k = 0; k < 5; k++) ec[k] = 0;
        pre = mst[c][a];
        rd  = 0;
        if (op == 2) begin
            if (pre == 3) begin mmem[a] = mdat[c][a]; ec[4]++; end
            mst[c][a] = 0;
        end else begin
            for (int b = 0; b < NA; b++) begin
                if (b != a && (b % 4) == (a % 4) && mst[c][b] != 0) begin
                    if (mst[c][b] == 3) begin mmem[b] = mdat[c][b]; ec[4]++; end
                    mst[c][b] = 0;
                end
            end
            if (mst[c][a] == 0) begin
                ec[1]++;
                if (mst[o][a] == 3) begin mmem[a] = mdat[o][a]; mst[o][a] = 1; end
                else if (mst[o][a] == 2) mst[o][a] = 1;
                mdat[c][a] = mmem[a];
                mst[c][a]  = 1;
            end
            if (op == 0) rd = mdat[c][a];
            else begin
                cur = mst[c][a];
                if (mode == 2'd0) begin
                    ec[2]++; mmem[a] = wd; mst[o][a] = 0; mst[c][a] = 1;
                end else if (mode == 2'd1) begin
                    if (cur == 1) begin ec[3]++; mst[o][a] = 0; end
                    mst[c][a] = 3;
                end else begin
                    if (cur == 1) begin ec[2]++; mmem[a] = wd; mst[o][a] = 0; mst[c][a] = 2; end
                    else mst[c][a] = 3;
                end
                mdat[c][a] = wd;
            end
        end
        post = mst[c][a];

        for (int k = 0; k < 5; k++) bus_cnt[k] = 0;
        cpu_req[c]          = 1'b1;
        cpu_op[c*2 +: 2]    = op[1:0];
        cpu_addr[c*AW +: AW] = a[AW-1:0];
        cpu_wdata[c*DW +: DW] = wd[DW-1:0];
        @(negedge clk);
        cpu_req[c] = 1'b0;
        guard = 0;
        while (!cpu_done[c] && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        check("R10", "done seen", int'(cpu_done[c]), 1);
        ptag = (mode == 2'd0) ? "R4" : (mode == 2'd1) ? "R5" : "R6";
        check("R7", $sformatf("pre state cpu%0d addr%0d", c, a), int'(cpu_pre_state[c*2 +: 2]), pre);
        check(ptag, $sformatf("post state cpu%0d addr%0d", c, a), int'(cpu_post_state[c*2 +: 2]), post);
        if (op == 0) check("R2", "read data", int'(cpu_rdata[c*DW +: DW]), rd);
        check("R2", "bus reads", bus_cnt[1], ec[1]);
        check(ptag, "bus writes", bus_cnt[2], ec[2]);
        check("R5", "bus invalidates", bus_cnt[3], ec[3]);
        check((op == 2) ? "R9" : "R8", "bus write-backs", bus_cnt[4], ec[4]);
        @(negedge clk);
        check("R10", "done one cycle", int'(cpu_done[c]), 0);
        bad = 0; bad_a = 0;
        for (int b = 0; b < NA; b++) begin
            if (int'(mem_arr[b]) != mmem[b]) begin
                if (bad == 0) bad_a = b;
                bad++;
            end
        end
        check("R3", $sformatf("memory word %0d", bad_a), int'(mem_arr[bad_a]), mmem[bad_a]);
    endtask

    initial begin
        for (int md = 0; md < 3; md++) begin
            start(md);
            // X = 5: P read, Q read, Q write, Q read, Q write, P write, Q read
            do_op(0, 0, 5, 0);
            do_op(1, 0, 5, 0);
            do_op(1, 1, 5, 8'h21);
            do_op(1, 0, 5, 0);
            do_op(1, 1, 5, 8'h22);
            do_op(0, 1, 5, 8'h23);
            do_op(1, 0, 5, 0);
            // frame conflicts (addresses 5, 9, 13 share frame 1)
            do_op(0, 0, 9, 0);
            do_op(0, 1, 9, 8'h30);
            do_op(0, 1, 9, 8'h31);
            do_op(1, 1, 13, 8'h40);
            do_op(0, 0, 13, 0);
            do_op(0, 2, 13, 0);
            do_op(1, 1, 13, 8'h41);
            do_op(1, 2, 13, 0);
            do_op(1, 2, 13, 0);
            do_op(0, 0, 5, 0);
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule